// File: doc/BRIEF.md
# Interleaved Two-Phase Clock Manager

This block is the timing core of a controller that runs two power branches in interleave. A saturating up/down counter takes the place of an analog timing ramp. It counts up to an upper bound, then counts down to a lower bound. The stretch of the cycle spent counting down is seen at the port as the synchronisation strobe. Each rising edge of that strobe picks the next branch in strict alternation and arms a clock latch for that branch. The latch drives the branch clock once the strobe falls. The clock stays high until that branch reports that its switch driver has turned on.

When the armed branch's driver has not yet turned on by the time the strobe falls, the counter keeps counting down, stopping at zero if it gets there. No new up-count starts until the driver turns on. This holds the two branches half a period apart even when each branch has to wait for its inductor to reset. A driver that follows its clock at once produces a one-cycle clock pulse. Dropping the enable input puts the block back in its idle state.

Top module: `ilv_clock_mgr`

## Requirements
- R1: While `enable` is low, after the next clock edge `syncOut`, `branchClkA` and `branchClkB` are 0, `phaseTwo` is 1 and the ramp is 0. Rising edges on the driver inputs in this state have no effect on the outputs.
- R2: `syncOut` goes high on the edge after the ramp exceeds `HI_TH`. It stays high until the ramp is below `LO_TH`. With the defaults (bounds 40 and 8, steps 4) it is high for exactly 10 cycles.
- R3: `phaseTwo` (0 = branch A selected, 1 = branch B selected) flips on every rising edge of `syncOut`. The first strobe after enable selects branch A.
- R4: The selected branch's clock is 0 while `syncOut` is high. It is 1 in the first cycle after `syncOut` falls. The other branch's clock stays 0.
- R5: A branch clock stays high for as long as its own driver input stays low. A rising edge on the other branch's driver input does not clear it.
- R6: A rising edge on a branch's own driver input clears that branch's clock one cycle later. A driver that follows its clock at once gives a clock pulse exactly 1 cycle wide.
- R7: While a branch clock is pending after the strobe, `syncOut` stays low and no new up-count starts. With the defaults, the next strobe rises 13 cycles after the driver input is raised.
- R8: While the count-down is stretched, the ramp saturates at 0 and does not wrap. The delay from the driver rising to the next strobe therefore does not depend on how long the stretch lasted.
- R9: The two branch clocks are never high together. Over a run, each branch receives clocks on alternate strobes only, so each branch runs at no more than half the ramp frequency.
- R10: With the defaults, the first strobe after `enable` rises is seen 12 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable; low returns the block to idle |
| drvOnA | input | 1 | Branch A driver-on state |
| drvOnB | input | 1 | Branch B driver-on state |
| branchClkA | output | 1 | Branch A clock |
| branchClkB | output | 1 | Branch B clock |
| syncOut | output | 1 | Synchronisation strobe (ramp counting down) |
| phaseTwo | output | 1 | Active-branch flag, 1 = branch B |

## Verification
The assertions assume that a driver input rises only once its own branch clock has been released. They also assume that `enable` and the driver inputs change only between clock edges. Where a property's consequent could be cut short by the block being disabled, the property allows for it. The stimulus changes every input on the falling clock edge. Driver inputs are raised only after the matching clock has been seen high. The one exception is a pulse on the opposite branch, or a pulse while disabled, and there the property consequents still hold.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    ST_CHARGE = 2'd0,
    ST_DISCH  = 2'd1,
    ST_HOLD   = 2'd2
  } rampState_t;

  // strobes from the sequencer to the ramp datapath
  typedef struct packed {
    logic clear;
    logic up;
    logic down;
  } rampCmd_t;

  // comparator results from the datapath back to the sequencer
  typedef struct packed {
    logic aboveHi;
    logic belowLo;
  } rampFlag_t;

endpackage

// File: rtl/ilv_ramp_dp.sv
module ilv_ramp_dp
  import ilv_pkg::*;
#(
  parameter int RAMP_W  = 8,
  parameter int HI_TH   = 40,
  parameter int LO_TH   = 8,
  parameter int UP_STEP = 4,
  parameter int DN_STEP = 4,
  parameter int NUM_BR  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rampCmd_t          cmd,
  input  logic [NUM_BR-1:0] drvOn,
  output rampFlag_t         flags,
  output logic [NUM_BR-1:0] drvRise,
  output logic [RAMP_W-1:0] rampVal
);

  localparam logic [RAMP_W:0]   RAMP_MAX = {1'b0, {RAMP_W{1'b1}}};
  localparam logic [RAMP_W:0]   UP_X     = (RAMP_W+1)'(UP_STEP);
  localparam logic [RAMP_W-1:0] DN_V     = RAMP_W'(DN_STEP);
  localparam logic [RAMP_W-1:0] HI_V     = RAMP_W'(HI_TH);
  localparam logic [RAMP_W-1:0] LO_V     = RAMP_W'(LO_TH);

  logic [RAMP_W:0]   upSum;
  logic [RAMP_W-1:0] upVal;
  logic [RAMP_W-1:0] dnVal;
  logic [RAMP_W-1:0] rampNext;
  logic [NUM_BR-1:0] drvPrev;

  // saturating step in both directions
  always_comb begin
    upSum = {1'b0, rampVal} + UP_X;
    upVal = (upSum > RAMP_MAX) ? RAMP_MAX[RAMP_W-1:0] : upSum[RAMP_W-1:0];
    dnVal = (rampVal >= DN_V) ? (rampVal - DN_V) : '0;
  end

  always_comb begin
    if (cmd.clear)     rampNext = '0;
    else if (cmd.up)   rampNext = upVal;
    else if (cmd.down) rampNext = dnVal;
    else               rampNext = rampVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rampVal <= '0;
    else       rampVal <= rampNext;
  end

  always_comb begin
    flags.aboveHi = (rampVal > HI_V);
    flags.belowLo = (rampVal < LO_V);
  end

  // driver rising-edge detectors, one per branch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) drvPrev <= '0;
    else       drvPrev <= drvOn;
  end

  for (genvar i = 0; i < NUM_BR; i++) begin : g_edge
    assign drvRise[i] = drvOn[i] & ~drvPrev[i];
  end

endmodule

// File: rtl/ilv_branch_latch.sv
module ilv_branch_latch (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic setReq,
  input  logic drvRise,
  output logic held
);

  // arm has priority over the driver edge; disable clears everything
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        held <= 1'b0;
    else if (clear)   held <= 1'b0;
    else if (setReq)  held <= 1'b1;
    else if (drvRise) held <= 1'b0;
  end

endmodule

// File: rtl/ilv_phase_ctrl.sv
module ilv_phase_ctrl
  import ilv_pkg::*;
#(
  parameter int NUM_BR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  rampFlag_t         flags,
  input  logic [NUM_BR-1:0] drvRise,
  output rampCmd_t          cmd,
  output logic              syncOut,
  output logic              phaseTwo,
  output logic [NUM_BR-1:0] branchClk
);

  rampState_t        st;
  rampState_t        stNext;
  logic              armStrobe;
  logic              pending;
  logic [NUM_BR-1:0] setVec;
  logic [NUM_BR-1:0] latchQ;

  assign pending = latchQ[phaseTwo];

  always_comb begin
    stNext    = st;
    cmd       = '0;
    armStrobe = 1'b0;
    if (!enable) begin
      cmd.clear = 1'b1;
      stNext    = ST_CHARGE;
    end else begin
      unique case (st)
        ST_CHARGE: begin
          if (flags.aboveHi) begin
            stNext    = ST_DISCH;
            cmd.down  = 1'b1;
            armStrobe = 1'b1;
          end else begin
            cmd.up = 1'b1;
          end
        end
        ST_DISCH: begin
          cmd.down = 1'b1;
          if (flags.belowLo) stNext = ST_HOLD;
        end
        ST_HOLD: begin
          // stretched count-down until the selected driver has turned on
          if (pending) begin
            cmd.down = 1'b1;
          end else begin
            cmd.up = 1'b1;
            stNext = ST_CHARGE;
          end
        end
        default: stNext = ST_CHARGE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_CHARGE;
    else       st <= stNext;
  end

  // divide-by-two on the strobe; idle value makes the next pick branch A
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          phaseTwo <= 1'b1;
    else if (!enable)   phaseTwo <= 1'b1;
    else if (armStrobe) phaseTwo <= ~phaseTwo;
  end

  assign syncOut = (st == ST_DISCH);

  for (genvar i = 0; i < NUM_BR; i++) begin : g_br
    assign setVec[i] = armStrobe && (~phaseTwo == 1'(i));

    ilv_branch_latch u_latch (
      .clk     (clk),
      .rstN    (rstN),
      .clear   (!enable),
      .setReq  (setVec[i]),
      .drvRise (drvRise[i]),
      .held    (latchQ[i])
    );

    assign branchClk[i] = latchQ[i] & ~syncOut;
  end

endmodule

// File: rtl/ilv_clock_mgr.sv
module ilv_clock_mgr
  import ilv_pkg::*;
#(
  parameter int RAMP_W  = 8,
  parameter int HI_TH   = 40,
  parameter int LO_TH   = 8,
  parameter int UP_STEP = 4,
  parameter int DN_STEP = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic drvOnA,
  input  logic drvOnB,
  output logic branchClkA,
  output logic branchClkB,
  output logic syncOut,
  output logic phaseTwo
);

  localparam int NUM_BR = 2;

  rampCmd_t          cmd;
  rampFlag_t         flags;
  logic [NUM_BR-1:0] drvRise;
  logic [NUM_BR-1:0] branchClk;
  logic [RAMP_W-1:0] rampVal;

  ilv_ramp_dp #(
    .RAMP_W  (RAMP_W),
    .HI_TH   (HI_TH),
    .LO_TH   (LO_TH),
    .UP_STEP (UP_STEP),
    .DN_STEP (DN_STEP),
    .NUM_BR  (NUM_BR)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .drvOn   ({drvOnB, drvOnA}),
    .flags   (flags),
    .drvRise (drvRise),
    .rampVal (rampVal)
  );

  ilv_phase_ctrl #(
    .NUM_BR (NUM_BR)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .flags     (flags),
    .drvRise   (drvRise),
    .cmd       (cmd),
    .syncOut   (syncOut),
    .phaseTwo  (phaseTwo),
    .branchClk (branchClk)
  );

  assign branchClkA = branchClk[0];
  assign branchClkB = branchClk[1];

endmodule

// File: rtl/ilv_clock_chk.sv
module ilv_clock_chk #(
  parameter int RAMP_W = 8,
  parameter int LO_TH  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              drvOnA,
  input logic              drvOnB,
  input logic              branchClkA,
  input logic              branchClkB,
  input logic              syncOut,
  input logic              phaseTwo,
  input logic [RAMP_W-1:0] rampVal
);

  localparam logic [RAMP_W-1:0] LO_V = RAMP_W'(LO_TH);

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!syncOut && !branchClkA && !branchClkB && phaseTwo && rampVal == '0));

  assert_sync_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && syncOut && rampVal >= LO_V) |=> (syncOut || !enable));

  assert_phase_flip_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOut) |-> (phaseTwo != $past(phaseTwo)));

  assert_sync_masks_clk_R4: assert property (@(posedge clk) disable iff (!rstN)
    syncOut |-> (!branchClkA && !branchClkB));

  assert_hold_a_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && branchClkA && !drvOnA) |=> (branchClkA || !enable));

  assert_hold_b_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && branchClkB && !drvOnB) |=> (branchClkB || !enable));

  assert_stretch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && (branchClkA || branchClkB)) |=> (!syncOut));

  assert_floor_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rampVal == '0 && !syncOut && (branchClkA || branchClkB)) |=> (rampVal == '0 || !enable));

  assert_one_clock_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({branchClkA, branchClkB}));

endmodule

bind ilv_clock_mgr ilv_clock_chk #(
  .RAMP_W (RAMP_W),
  .LO_TH  (LO_TH)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .drvOnA     (drvOnA),
  .drvOnB     (drvOnB),
  .branchClkA (branchClkA),
  .branchClkB (branchClkB),
  .syncOut    (syncOut),
  .phaseTwo   (phaseTwo),
  .rampVal    (rampVal)
);

// File: tb/test_ilv_clock_mgr.sv
module test_ilv_clock_mgr;

  logic clk = 1'b0;
  logic rstN;
  logic enable;
  logic drvOnA;
  logic drvOnB;
  logic branchClkA;
  logic branchClkB;
  logic syncOut;
  logic phaseTwo;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;
  int delayA = 0;

  always #5 clk = ~clk;

  ilv_clock_mgr i_ilv_clock_mgr (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .drvOnA     (drvOnA),
    .drvOnB     (drvOnB),
    .branchClkA (branchClkA),
    .branchClkB (branchClkB),
    .syncOut    (syncOut),
    .phaseTwo   (phaseTwo)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // counts rising clock edges until syncOut is seen high at a falling edge
  task automatic countToSync(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!syncOut && n < 300);
  endtask

  task automatic tReset();
    @(negedge clk);
    checkEq("R1 reset sync", int'(syncOut), 0);
    checkEq("R1 reset clkA", int'(branchClkA), 0);
    checkEq("R1 reset clkB", int'(branchClkB), 0);
    checkEq("R1 reset phase flag", int'(phaseTwo), 1);
  endtask

  task automatic tStartup();
    int n;
    int w;
    enable = 1'b1;
    countToSync(n);
    checkEq("R10 first strobe delay", n, 12);
    checkEq("R3 first pick is branch A", int'(phaseTwo), 0);
    checkEq("R4 clkA masked during strobe", int'(branchClkA), 0);
    w = 0;
    while (syncOut && w < 300) begin
      w++;
      @(negedge clk);
    end
    checkEq("R2 strobe width", w, 10);
    checkEq("R4 clkA after strobe", int'(branchClkA), 1);
    checkEq("R4 clkB idle", int'(branchClkB), 0);
  endtask

  task automatic tHold();
    int n;
    repeat (30) @(negedge clk);
    checkEq("R5 clkA held", int'(branchClkA), 1);
    checkEq("R7 no strobe while pending", int'(syncOut), 0);
    drvOnB = 1'b1;
    @(negedge clk);
    drvOnB = 1'b0;
    @(negedge clk);
    checkEq("R5 other driver ignored", int'(branchClkA), 1);
    drvOnA = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkEq("R6 clkA cleared by driver", int'(branchClkA), 0);
    countToSync(n);
    delayA = n + 1;
    checkEq("R7 strobe delay after long stretch", delayA, 13);
    drvOnA = 1'b0;
    checkEq("R3 second pick is branch B", int'(phaseTwo), 1);
  endtask

  task automatic tImmediate();
    int n;
    int guard = 0;
    while (syncOut && guard < 300) begin
      guard++;
      @(negedge clk);
    end
    checkEq("R4 clkB after strobe", int'(branchClkB), 1);
    checkEq("R9 clkA idle on B turn", int'(branchClkA), 0);
    drvOnB = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkEq("R6 short pulse", int'(branchClkB), 0);
    countToSync(n);
    checkEq("R8 delay after short stretch", n + 1, 13);
    checkEq("R8 delay independent of stretch", n + 1, delayA);
    drvOnB = 1'b0;
  endtask

  task automatic tAlternate();
    int riseA = 0, riseB = 0, syncRise = 0, both = 0, badFlip = 0;
    bit prevA = 1'b0, prevB = 1'b0, prevS = 1'b0, prevP = 1'b0;
    @(negedge clk);
    prevA = branchClkA; prevB = branchClkB; prevS = syncOut; prevP = phaseTwo;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      drvOnA = branchClkA;
      drvOnB = branchClkB;
      if (branchClkA && branchClkB) both++;
      if (branchClkA && !prevA) riseA++;
      if (branchClkB && !prevB) riseB++;
      if (syncOut && !prevS) begin
        syncRise++;
        if (phaseTwo == prevP) badFlip++;
      end
      prevA = branchClkA; prevB = branchClkB; prevS = syncOut; prevP = phaseTwo;
    end
    drvOnA = 1'b0;
    drvOnB = 1'b0;
    checkEq("R9 never both clocks", both, 0);
    checkEq("R3 flag flips each strobe", badFlip, 0);
    checkEq("R9 branches alternate", int'((riseA - riseB) <= 1 && (riseB - riseA) <= 1), 1);
    checkEq("R9 one clock per strobe", int'((riseA + riseB == syncRise) || (riseA + riseB == syncRise - 1)), 1);
    checkEq("R9 enough strobes seen", int'(syncRise >= 8), 1);
  endtask

  task automatic tDisable();
    int n;
    int guard = 0;
    while (!(branchClkA || branchClkB) && guard < 300) begin
      guard++;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(posedge clk);
    @(negedge clk);
    checkEq("R1 disable clears clkA", int'(branchClkA), 0);
    checkEq("R1 disable clears clkB", int'(branchClkB), 0);
    checkEq("R1 disable sync", int'(syncOut), 0);
    checkEq("R1 disable phase flag", int'(phaseTwo), 1);
    drvOnA = 1'b1;
    @(negedge clk);
    drvOnA = 1'b0;
    drvOnB = 1'b1;
    @(negedge clk);
    drvOnB = 1'b0;
    @(negedge clk);
    checkEq("R1 drivers ignored when off", int'(branchClkA | branchClkB | syncOut), 0);
    enable = 1'b1;
    countToSync(n);
    checkEq("R10 strobe delay after re-enable", n, 12);
    checkEq("R3 re-enable picks branch A", int'(phaseTwo), 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        finishRun();
      end
    end
  end

  initial begin
    rstN   = 1'b0;
    enable = 1'b0;
    drvOnA = 1'b0;
    drvOnB = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tStartup();
    tHold();
    tImmediate();
    tAlternate();
    tDisable();
    finishRun();
  end

endmodule